// File: doc/BRIEF.md
# Fly-by DMA Controller

This block is a single-channel DMA engine that moves a block of words between one I/O device and memory. Each word takes one bus access. The data does not pass through the controller. Instead, the controller opens a read strobe on one side and a write strobe on the other in the same cycle, and the data travels straight across the shared data bus. Software first loads a memory start address, a word count and a direction, and then sets a start bit.

The device paces the transfer. While its service request is high, the controller asks the host processor for the bus and waits for the grant. It then runs accesses, each one strobe cycle followed by one idle cycle, and advances the memory address after every word. If the device request drops or the grant is withdrawn, the controller finishes the access in flight and releases the bus. It asks for the bus again later and resumes from the saved address and count.

When the count is used up, the controller drops its bus request and its output enable, sets a done flag and gives a one-cycle interrupt pulse.

Top module: `flyby_dma`

## Requirements
- R1: A configuration write with selector 0 loads the memory start address, selector 1 loads the word count (low CW bits of the data) and selector 2 is the control word. In the control word, bit 0 = 1 starts a block and bit 1 sets the direction: 0 means device-to-memory, 1 means memory-to-device. Starting a block with a nonzero count clears done.
- R2: A bus request (`hold_req`) is raised only after the device request was sampled high while a block is active. It appears one cycle after that sample.
- R3: `bus_oe`, the memory address and the strobes are driven only after `hold_ack` was sampled high in response to the bus request.
- R4: In device-to-memory mode, every access drives `dev_rd_n` and `mem_wr_n` low in the same cycle, while `mem_rd_n` and `dev_wr_n` stay high.
- R5: In memory-to-device mode, every access drives `mem_rd_n` and `dev_wr_n` low in the same cycle, while `dev_rd_n` and `mem_wr_n` stay high.
- R6: Each access lasts exactly one cycle and is followed by at least one cycle with all strobes high. Successive accesses use successive memory addresses, starting at the programmed address and wrapping modulo 2^AW.
- R7: No access starts unless the device request was high at the clock edge that starts it.
- R8: After exactly count accesses, the following happens two cycles after the last access: `hold_req` and `bus_oe` are low, `done` is high and `irq` is high for exactly one cycle.
- R9: Starting with a count of zero sets `done` and pulses `irq` in the next cycle, and no bus request follows.
- R10: If the grant drops during a block, the current access completes and the bus is released. The bus is then requested again, and the block continues from the next address until all count words have moved.
- R11: While a block is active, all configuration writes, including the start bit, are ignored. The block completes with its original address, count and direction.
- R12: `bus_oe` is high only while `hold_req` is high. While `bus_oe` is low, all strobes are high and `mem_addr` is zero.
- R13: During reset and right after it, `hold_req`, `bus_oe`, `done` and `irq` are low and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register selector: 0 address, 1 count, 2 control |
| cfg_wdata | input | AW | Configuration write data |
| dev_req | input | 1 | Service request from the I/O device |
| hold_ack | input | 1 | Bus grant from the processor |
| hold_req | output | 1 | Bus request to the processor |
| bus_oe | output | 1 | Output enable for address and strobes |
| mem_addr | output | AW | Memory address of the current word |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| done | output | 1 | Set when a block completes, cleared by a new start |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench drives inputs on the falling edge and samples outputs 2 ns after each rising edge. At that moment every input still holds the value the design just sampled, so each result can be checked against exactly the input that caused it.

Latencies:
- `hold_req` rises in the first sample after `dev_req` is seen high.
- An access appears in the first sample after a sampled grant.
- `done` and `irq` appear two samples after the last access.
- A zero-count start shows `done` at the falling edge right after the start edge.

The processor model withholds a new grant until the request has been dropped, so a withdrawn grant always forces a full release and a new request.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_GAP
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;
endpackage

// File: rtl/flyby_dma_cfg.sv
module flyby_dma_cfg
  import flyby_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [1:0] ctrl_bits,
  output logic       ld_addr,
  output logic       ld_cnt,
  output logic       go,
  output logic       dir_q
);
  logic wr_ok;
  logic dir_d;
  logic dir_en;

  always_comb begin
    wr_ok   = cfg_we && !busy;
    ld_addr = wr_ok && (cfg_sel == SEL_ADDR);
    ld_cnt  = wr_ok && (cfg_sel == SEL_CNT);
    dir_en  = wr_ok && (cfg_sel == SEL_CTRL);
    go      = dir_en && ctrl_bits[CTRL_GO_BIT];
    dir_d   = ctrl_bits[CTRL_DIR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  // R11: direction frozen while a block runs
  p_dir_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dir_q));
endmodule

// File: rtl/flyby_dma_ptr.sv
module flyby_dma_ptr #(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] addr_q,
  output logic          cnt_zero
);
  localparam logic [AW-1:0] ADDR_INC = AW'(STEP);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          addr_en;
  logic          cnt_en;

  always_comb begin
    addr_en = ld_addr || step;
    cnt_en  = ld_cnt || step;
    addr_d  = ld_addr ? wdata : (addr_q + ADDR_INC);
    cnt_d   = ld_cnt ? wdata[CW-1:0] : (cnt_q - CNT_ONE);
    cnt_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R8: the sequencer never steps an exhausted counter
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cnt_zero);
  // R6: every word moves the address forward by one step
  p_addr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_addr) |=> (addr_q == $past(addr_q) + ADDR_INC));
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import flyby_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cnt_zero,
  input  logic dev_req,
  input  logic hold_ack,
  output logic busy,
  output logic step,
  output logic hold_req,
  output logic bus_oe,
  output logic xfer,
  output logic done,
  output logic irq
);
  seq_state_e st_q, st_d;
  logic       fin;
  logic       done_d;

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) fin = 1'b1;
          else          st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dev_req) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (!dev_req)      st_d = ST_WAIT;
        else if (hold_ack) st_d = ST_XFER;
      end
      ST_XFER: begin
        st_d = ST_GAP;
      end
      ST_GAP: begin
        if (cnt_zero) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end else if (!hold_ack || !dev_req) begin
          st_d = ST_WAIT;
        end else begin
          st_d = ST_XFER;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    done_d = fin ? 1'b1 : (go ? 1'b0 : done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      irq  <= fin;
    end
  end

  always_comb begin
    busy     = (st_q != ST_IDLE);
    step     = (st_q == ST_XFER);
    xfer     = (st_q == ST_XFER);
    bus_oe   = (st_q == ST_XFER) || (st_q == ST_GAP);
    hold_req = bus_oe || (st_q == ST_REQ);
  end

  // R6: one strobe cycle, then at least one idle cycle
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
  // R8: completion pulse lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10: after losing the grant the bus is not kept
  p_release_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && !hold_ack) |=> !bus_oe);
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dev_req,
  input  logic          hold_ack,
  output logic          hold_req,
  output logic          bus_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic          done,
  output logic          irq
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          busy, ld_addr, ld_cnt, go, dir_q;
  logic          step, xfer, cnt_zero;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  flyby_dma_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy      (busy),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .ctrl_bits (cfg_wdata[1:0]),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .go        (go),
    .dir_q     (dir_q)
  );

  flyby_dma_ptr #(.AW(AW), .CW(CW), .STEP(STEP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt),
    .wdata    (cfg_wdata),
    .step     (step),
    .addr_q   (addr_q),
    .cnt_zero (cnt_zero)
  );

  flyby_dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (go),
    .cnt_zero (cnt_zero),
    .dev_req  (dev_req),
    .hold_ack (hold_ack),
    .busy     (busy),
    .step     (step),
    .hold_req (hold_req),
    .bus_oe   (bus_oe),
    .xfer     (xfer),
    .done     (done),
    .irq      (irq)
  );

  always_comb begin
    dev_rd_n = !(xfer && !dir_q);
    mem_wr_n = !(xfer && !dir_q);
    mem_rd_n = !(xfer && dir_q);
    dev_wr_n = !(xfer && dir_q);
    mem_addr = bus_oe ? addr_q : '0;
  end

  // R3: the bus is driven only after a sampled grant
  p_drive_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_oe) |-> $past(hold_ack));
  // R4: device-to-memory access pairs device read with memory write
  p_pair_in_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dev_rd_n |-> (!mem_wr_n && mem_rd_n && dev_wr_n));
  // R5: memory-to-device access pairs memory read with device write
  p_pair_out_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_rd_n |-> (!dev_wr_n && mem_wr_n && dev_rd_n));
  // R7: an access is always paced by a sampled device request
  p_paced_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(xfer) |-> $past(dev_req));
  // R12: output enable only under an outstanding bus request
  p_oe_under_req_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_oe |-> hold_req);
  // R2: a bus request starts only from a sampled device request
  p_req_paced_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_req) |-> $past(dev_req));
endmodule

// File: tb/test_flyby_dma.sv
module test_flyby_dma;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          dev_req, hold_ack;
  logic          hold_req, bus_oe, mem_rd_n, mem_wr_n, dev_rd_n, dev_wr_n, done, irq;
  logic [AW-1:0] mem_addr;

  flyby_dma i_flyby_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dev_req(dev_req), .hold_ack(hold_ack), .hold_req(hold_req), .bus_oe(bus_oe),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .done(done), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  bit  mon_en = 0;
  int  dev_mode = 0;          // 0 low, 1 high, 2 random
  bit  drop_en = 0;
  int  drop_word = 0;
  int  lat_max = 0;
  logic [AW-1:0] exp_addr;
  bit  exp_dir;
  int  words, irq_cnt, req_rises;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pattern_ok(input bit dir, input logic [3:0] s);
    // s = {mem_rd_n, mem_wr_n, dev_rd_n, dev_wr_n}
    return dir ? (s == 4'b0110) : (s == 4'b1001);
  endfunction

  // device and processor models, inputs change on the falling edge
  initial begin
    int  wait_cnt = 0, lat = 0;
    bit  need_release = 0, dropped = 0;
    dev_req = 1'b0; hold_ack = 1'b0;
    forever begin
      @(negedge clk);
      case (dev_mode)
        0: dev_req = 1'b0;
        1: dev_req = 1'b1;
        default: dev_req = ($urandom % 4) != 0;
      endcase
      if (drop_word == 0) dropped = 0;
      if (!hold_req) begin
        hold_ack = 1'b0; wait_cnt = 0; need_release = 0;
      end else if (!hold_ack) begin
        if (!need_release) begin
          if (wait_cnt >= lat) begin
            hold_ack = 1'b1; wait_cnt = 0; lat = (lat_max > 0) ? int'($urandom % lat_max) : 0;
          end else wait_cnt++;
        end
      end else if ((drop_en && ($urandom % 5) == 0) ||
                   (drop_word > 0 && words == drop_word && !dropped)) begin
        hold_ack = 1'b0; need_release = 1; dropped = 1;
      end
    end
  end

  // output monitor, 2 ns after each rising edge
  bit prev_access = 0, prev_oe = 0, prev_hold = 0, prev_done = 0;
  int since_last = 0;
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      logic [3:0] s;
      bit access;
      s = {mem_rd_n, mem_wr_n, dev_rd_n, dev_wr_n};
      access = (s != 4'b1111);
      if (!bus_oe) chk(!access && mem_addr == '0, "R12 idle bus quiet", {s, mem_addr}, {4'hF, 16'h0});
      if (bus_oe)  chk(hold_req, "R12 oe under request", hold_req, 1);
      if (bus_oe && !prev_oe) chk(hold_ack, "R3 grant before drive", hold_ack, 1);
      if (hold_req && !prev_hold) begin
        chk(dev_req, "R2 request paced by device", dev_req, 1);
        req_rises++;
      end
      if (access) begin
        chk(bus_oe, "R3 strobe with oe", bus_oe, 1);
        chk(!prev_access, "R6 idle cycle between words", prev_access, 0);
        chk(mem_addr == exp_addr, "R6 address sequence", mem_addr, exp_addr);
        chk(pattern_ok(exp_dir, s), exp_dir ? "R5 out strobes" : "R4 in strobes", s,
            exp_dir ? 4'b0110 : 4'b1001);
        chk(dev_req, "R7 access paced by device", dev_req, 1);
        exp_addr = exp_addr + 1'b1;
        words++;
        since_last = 0;
      end else since_last++;
      if (irq) irq_cnt++;
      if (done && !prev_done && words > 0) begin
        chk(since_last == 2, "R8 completion latency", since_last, 2);
        chk(!hold_req && !bus_oe && irq, "R8 release and pulse", {hold_req, bus_oe, irq}, 3'b001);
      end
      prev_access = access; prev_oe = bus_oe; prev_hold = hold_req; prev_done = done;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input logic [AW-1:0] addr, input int cnt, input bit dir,
                           input int mode, input bit drop, input int dword,
                           input int lat, input int hold_off, input bit poke);
    int t;
    exp_addr = addr; exp_dir = dir; words = 0; irq_cnt = 0; req_rises = 0;
    drop_en = drop; drop_word = dword; lat_max = lat;
    dev_mode = (hold_off > 0) ? 0 : mode;
    wr(2'd0, addr);
    wr(2'd1, AW'(cnt));
    wr(2'd2, {14'd0, dir, 1'b1});
    chk(!done, "R1 start clears done", done, 0);
    if (hold_off > 0) begin
      for (int i = 0; i < hold_off; i++) begin
        @(negedge clk);
        chk(!hold_req && words == 0, "R7 no request without device", hold_req, 0);
      end
      dev_mode = mode;
    end
    if (poke) begin
      wait (words >= 1);
      wr(2'd0, addr ^ 16'h00F0);
      wr(2'd1, AW'(cnt + 5));
      wr(2'd2, {14'd0, ~dir, 1'b1});
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, "R8 block completes", done, 1);
    repeat (3) @(negedge clk);
    chk(words == cnt, poke ? "R11 original count kept" : (drop || dword > 0) ? "R10 all words after regrant" : "R8 word count",
        words, cnt);
    chk(irq_cnt == 1, "R8 single irq", irq_cnt, 1);
    if (dword > 0) chk(req_rises >= 2, "R10 bus requested again", req_rises, 2);
    dev_mode = 0; drop_en = 0; drop_word = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0D3A));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    chk(!hold_req && !bus_oe && !done && !irq, "R13 reset outputs", {hold_req, bus_oe, done, irq}, 0);
    chk({mem_rd_n, mem_wr_n, dev_rd_n, dev_wr_n} == 4'hF, "R13 reset strobes",
        {mem_rd_n, mem_wr_n, dev_rd_n, dev_wr_n}, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!hold_req && !bus_oe && !done && !irq, "R13 after reset", {hold_req, bus_oe, done, irq}, 0);
    mon_en = 1;

    // directed corner cases
    run_block(16'h0100, 1, 1'b0, 1, 0, 0, 0, 0, 0);   // R4 single word in
    run_block(16'h0200, 4, 1'b1, 1, 0, 0, 2, 0, 0);   // R5 out
    run_block(16'hFFFE, 4, 1'b0, 1, 0, 0, 0, 0, 0);   // R6 address wrap
    run_block(16'h0300, 3, 1'b1, 1, 0, 0, 1, 20, 0);  // R7 demand pacing
    run_block(16'h0400, 8, 1'b0, 1, 0, 3, 1, 0, 0);   // R10 grant drop mid-block
    run_block(16'h0500, 10, 1'b1, 1, 0, 0, 0, 0, 1);  // R11 writes while busy

    // R9 zero count
    irq_cnt = 0;
    wr(2'd1, '0);
    wr(2'd2, 16'h0001);
    chk(done && irq, "R9 zero count completes", {done, irq}, 2'b11);
    dev_mode = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!hold_req, "R9 no request on zero count", hold_req, 0);
    end
    dev_mode = 0;
    chk(irq_cnt == 1, "R9 single irq", irq_cnt, 1);

    // constrained random blocks
    for (int i = 0; i < 16; i++) begin
      run_block(AW'($urandom), 1 + int'($urandom % 12), bit'($urandom % 2),
                1 + int'($urandom % 2), bit'(i % 2), 0, int'($urandom % 4), 0, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule